// File: doc/BRIEF.md
# Timer Register Burst Access Window

This block fronts a plain timer register file with one extra "window" address. A control register selects a base row and a transfer count. Each read or write through the window lands on the row at base plus a running index, and then the index steps forward. After the programmed number of transfers the index returns to zero, so the next window access hits the base row again. Any master can use the window: a processor, a DMA engine or a debug port, all through the same single-cycle bus port. A DMA engine can therefore fetch several consecutive capture registers in order with repeated single-word reads of one address.

Every window access also raises a DMA request on each request line whose enable bit is set, whether or not that line's own event fired. Line events (`evtIn`) raise requests too when enabled. A raised request holds until its acknowledge is sampled high.

Address map, in word units: rows `0..NREGS-1` are the register file, `NREGS` is the control register, `NREGS+1` is the request-enable mask, and `NREGS+2` is the window. All other addresses read as zero and ignore writes.

Top module: `tmr_burst_window`

## Requirements
- R1: While `rstN` is low, and after it is released, the control fields, the index, the enable mask, every request and `busRdata` are zero. All register-file rows are also zero.
- R2: The control register holds the base in bits 7:0 and the transfer count minus one in bits 12:8. A read of it also returns the current index in bits 20:16, with all other bits zero. Unmapped addresses read zero.
- R3: A window read returns the row at base plus index on `busRdata`, from the clock edge that takes the access.
- R4: A window write stores `busWdata` into the row at base plus index.
- R5: Each window access advances the index by one. When the index equals the programmed count minus one, it wraps to zero instead.
- R6: A write to the control register sets the index to zero.
- R7: When base plus index lies beyond the last row, a window read returns zero and a window write changes no row. The index still advances.
- R8: Direct accesses to rows, the control register, the enable register and unmapped addresses leave the index unchanged.
- R9: A window access raises the request of every line whose bit is set in the enable mask (bit i enables line i). No `evtIn` pulse is needed for this.
- R10: An `evtIn` pulse raises the request of that line only when the line's enable bit is set.
- R11: A raised request stays high until its `reqAck` bit is sampled high in the same cycle. It is then low for at least the following cycle, even if a window access or event arrives in the acknowledge cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busValid | input | 1 | Access strobe, one access per cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Word address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, updated on the edge that takes a read |
| evtIn | input | NREQ | Per-line event pulses |
| reqAck | input | NREQ | Per-line request acknowledge |
| dmaReq | output | NREQ | Per-line DMA request |

## Verification
Every result of this block is due at the first rising edge that takes the access. Read data, the index step, row writes, control updates and newly raised or released requests all settle in that one cycle. The bench drives inputs and compares all outputs at falling edges, so each comparison falls half a cycle after the edge that produced the value. A behavioural model in the bench updates on the same edge and is compared with `busRdata` and `dmaReq` every cycle. Targeted checks then confirm the exact values for the wrap, out-of-range and acknowledge cases.

// File: rtl/tmr_burst_pkg.sv
`timescale 1ns/1ps
package tmr_burst_pkg;
  localparam int BASE_W  = 8;   // base field, bits 7:0
  localparam int LEN_W   = 5;   // count-minus-one field, bits 12:8
  localparam int CWORD_W = BASE_W + LEN_W;  // writable control bits
  localparam int TGT_W   = BASE_W + 1;      // base plus index without overflow

  typedef enum logic [1:0] {
    RD_ZERO = 2'd0,
    RD_FILE = 2'd1,
    RD_CTRL = 2'd2,
    RD_ENA  = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic             fileWr;
    logic [TGT_W-1:0] fileRow;
    rdSel_e           rdSel;
    logic             rdLoad;
  } strobe_t;
endpackage

// File: rtl/tmr_burst_ctrl.sv
`timescale 1ns/1ps
module tmr_burst_ctrl
  import tmr_burst_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int NREGS  = 8,
  parameter int NREQ   = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busValid,
  input  logic                busWrite,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [CWORD_W-1:0]  ctrlWdata,
  input  logic [NREQ-1:0]     evtIn,
  input  logic [NREQ-1:0]     reqAck,
  output strobe_t             stb,
  output logic [BASE_W-1:0]   baseCur,
  output logic [LEN_W-1:0]    lenCur,
  output logic [LEN_W-1:0]    idxCur,
  output logic [NREQ-1:0]     enaCur,
  output logic [NREQ-1:0]     dmaReq
);
  localparam logic [ADDR_W-1:0] FILE_END = ADDR_W'(NREGS);
  localparam logic [ADDR_W-1:0] CTRL_A   = ADDR_W'(NREGS);
  localparam logic [ADDR_W-1:0] ENA_A    = ADDR_W'(NREGS + 1);
  localparam logic [ADDR_W-1:0] WIN_A    = ADDR_W'(NREGS + 2);
  localparam logic [TGT_W-1:0]  ROW_END  = TGT_W'(NREGS);

  logic [BASE_W-1:0] baseQ;
  logic [LEN_W-1:0]  lenQ, idxQ;
  logic [NREQ-1:0]   enaQ, reqQ, setVec, reqD;
  logic              hitFile, hitCtrl, hitEna, hitWin, winInRange;
  logic [TGT_W-1:0]  winTgt;

  assign hitFile    = busValid && (busAddr < FILE_END);
  assign hitCtrl    = busValid && (busAddr == CTRL_A);
  assign hitEna     = busValid && (busAddr == ENA_A);
  assign hitWin     = busValid && (busAddr == WIN_A);
  assign winTgt     = TGT_W'(baseQ) + TGT_W'(idxQ);
  assign winInRange = winTgt < ROW_END;

  always_comb begin
    stb         = '0;
    stb.rdSel   = RD_ZERO;
    stb.rdLoad  = busValid && !busWrite;
    if (hitFile) begin
      stb.fileRow = TGT_W'(busAddr);
      stb.fileWr  = busWrite;
      stb.rdSel   = RD_FILE;
    end else if (hitCtrl) begin
      stb.rdSel   = RD_CTRL;
    end else if (hitEna) begin
      stb.rdSel   = RD_ENA;
    end else if (hitWin) begin
      stb.fileRow = winTgt;
      if (winInRange) begin
        stb.fileWr = busWrite;
        stb.rdSel  = RD_FILE;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ <= '0;
      lenQ  <= '0;
      idxQ  <= '0;
      enaQ  <= '0;
    end else begin
      if (hitCtrl && busWrite) begin
        baseQ <= ctrlWdata[BASE_W-1:0];
        lenQ  <= ctrlWdata[CWORD_W-1:BASE_W];
        idxQ  <= '0;
      end else if (hitWin) begin
        idxQ  <= (idxQ == lenQ) ? '0 : idxQ + LEN_W'(1);
      end
      if (hitEna && busWrite) enaQ <= ctrlWdata[NREQ-1:0];
    end
  end

  // request raise on window access or enabled event; acknowledge wins
  assign setVec = (hitWin ? enaQ : '0) | (evtIn & enaQ);
  assign reqD   = (reqQ & ~reqAck) | (setVec & ~(reqQ & reqAck));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) reqQ <= '0;
    else       reqQ <= reqD;
  end

  assign baseCur = baseQ;
  assign lenCur  = lenQ;
  assign idxCur  = idxQ;
  assign enaCur  = enaQ;
  assign dmaReq  = reqQ;
endmodule

// File: rtl/tmr_burst_datapath.sv
`timescale 1ns/1ps
module tmr_burst_datapath
  import tmr_burst_pkg::*;
#(
  parameter int NREGS = 8,
  parameter int NREQ  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [31:0]       busWdata,
  input  logic [BASE_W-1:0] baseCur,
  input  logic [LEN_W-1:0]  lenCur,
  input  logic [LEN_W-1:0]  idxCur,
  input  logic [NREQ-1:0]   enaCur,
  output logic [31:0]       busRdata
);
  localparam int PAD_W = 32 - (16 + LEN_W);

  logic [31:0] rowQ [NREGS];
  logic [31:0] fileData, ctrlView, enaView, rdataQ;

  for (genvar r = 0; r < NREGS; r++) begin : g_row
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        rowQ[r] <= '0;
      else if (stb.fileWr && (stb.fileRow == TGT_W'(r)))
        rowQ[r] <= busWdata;
    end
  end

  always_comb begin
    fileData = '0;
    for (int r = 0; r < NREGS; r++)
      if (stb.fileRow == TGT_W'(r)) fileData = rowQ[r];
  end

  assign ctrlView = {{PAD_W{1'b0}}, idxCur, 3'b000, lenCur, baseCur};
  assign enaView  = 32'(enaCur);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdataQ <= '0;
    else if (stb.rdLoad) begin
      unique case (stb.rdSel)
        RD_FILE: rdataQ <= fileData;
        RD_CTRL: rdataQ <= ctrlView;
        RD_ENA:  rdataQ <= enaView;
        default: rdataQ <= '0;
      endcase
    end
  end

  assign busRdata = rdataQ;
endmodule

// File: rtl/tmr_burst_window.sv
`timescale 1ns/1ps
module tmr_burst_window
  import tmr_burst_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int NREGS  = 8,
  parameter int NREQ   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic [NREQ-1:0]   evtIn,
  input  logic [NREQ-1:0]   reqAck,
  output logic [NREQ-1:0]   dmaReq
);
  strobe_t           stb;
  logic [BASE_W-1:0] baseCur;
  logic [LEN_W-1:0]  lenCur, idxCur;
  logic [NREQ-1:0]   enaCur;

  tmr_burst_ctrl #(.ADDR_W(ADDR_W), .NREGS(NREGS), .NREQ(NREQ)) u_ctrl (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .ctrlWdata(busWdata[CWORD_W-1:0]), .evtIn(evtIn),
    .reqAck(reqAck), .stb(stb), .baseCur(baseCur), .lenCur(lenCur),
    .idxCur(idxCur), .enaCur(enaCur), .dmaReq(dmaReq)
  );

  tmr_burst_datapath #(.NREGS(NREGS), .NREQ(NREQ)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .busWdata(busWdata),
    .baseCur(baseCur), .lenCur(lenCur), .idxCur(idxCur), .enaCur(enaCur),
    .busRdata(busRdata)
  );
endmodule

// File: rtl/tmr_burst_window_chk.sv
`timescale 1ns/1ps
module tmr_burst_window_chk
  import tmr_burst_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int NREGS  = 8,
  parameter int NREQ   = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              busValid,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [NREQ-1:0]   evtIn,
  input logic [NREQ-1:0]   reqAck,
  input logic [NREQ-1:0]   dmaReq,
  input logic [LEN_W-1:0]  idxCur,
  input logic [LEN_W-1:0]  lenCur,
  input logic [NREQ-1:0]   enaCur
);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(NREGS);
  localparam logic [ADDR_W-1:0] WIN_A  = ADDR_W'(NREGS + 2);

  logic winHit, ctrlWrHit, otherHit;
  assign winHit    = busValid && (busAddr == WIN_A);
  assign ctrlWrHit = busValid && busWrite && (busAddr == CTRL_A);
  assign otherHit  = busValid && (busAddr != WIN_A) && !ctrlWrHit;

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (|(dmaReq & ~reqAck)) |=> ((dmaReq & $past(dmaReq & ~reqAck)) == $past(dmaReq & ~reqAck)));

  assert_req_release_R11: assert property (@(posedge clk) disable iff (!rstN)
    (|(dmaReq & reqAck)) |=> ((dmaReq & $past(dmaReq & reqAck)) == '0));

  assert_win_request_R9: assert property (@(posedge clk) disable iff (!rstN)
    winHit |=> ((dmaReq & $past(enaCur & ~(dmaReq & reqAck))) == $past(enaCur & ~(dmaReq & reqAck))));

  assert_no_spurious_R10: assert property (@(posedge clk) disable iff (!rstN)
    !winHit && ((evtIn & enaCur) == '0) |=> ((dmaReq & ~$past(dmaReq)) == '0));

  assert_index_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    idxCur <= lenCur);

  assert_index_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    winHit |=> (idxCur == (($past(idxCur) == $past(lenCur)) ? '0 : $past(idxCur) + LEN_W'(1))));

  assert_ctrl_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWrHit |=> (idxCur == '0));

  assert_direct_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    otherHit |=> $stable(idxCur));
endmodule

bind tmr_burst_window tmr_burst_window_chk #(.ADDR_W(ADDR_W), .NREGS(NREGS), .NREQ(NREQ)) u_chk (
  .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr),
  .evtIn(evtIn), .reqAck(reqAck), .dmaReq(dmaReq), .idxCur(idxCur), .lenCur(lenCur),
  .enaCur(enaCur)
);

// File: tb/tmr_burst_window_tb.sv
`timescale 1ns/1ps
module tmr_burst_window_tb;
  localparam int ADDR_W = 6;
  localparam int NREGS  = 8;
  localparam int NREQ   = 4;
  localparam int CTRL_A = NREGS;
  localparam int ENA_A  = NREGS + 1;
  localparam int WIN_A  = NREGS + 2;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              busValid = 1'b0;
  logic              busWrite = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [31:0]       busWdata = '0;
  logic [31:0]       busRdata;
  logic [NREQ-1:0]   evtIn = '0;
  logic [NREQ-1:0]   reqAck = '0;
  logic [NREQ-1:0]   dmaReq;

  int compared = 0;
  int mismatched = 0;
  string curReq = "R1";
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tmr_burst_window #(.ADDR_W(ADDR_W), .NREGS(NREGS), .NREQ(NREQ)) u_dut (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .evtIn(evtIn), .reqAck(reqAck), .dmaReq(dmaReq)
  );

  // behavioural reference
  logic [31:0]     mRow [NREGS];
  int              mBase, mLen, mIdx;
  logic [NREQ-1:0] mEna, mReq, mSet, oldEna;
  logic [31:0]     mRd;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NREGS; i++) mRow[i] = '0;
      mBase = 0; mLen = 0; mIdx = 0; mEna = '0; mReq = '0; mRd = '0;
    end else begin
      int a, t;
      oldEna = mEna;
      mSet = evtIn & oldEna;
      if (busValid) begin
        a = int'(busAddr);
        if (a < NREGS) begin
          if (busWrite) mRow[a] = busWdata; else mRd = mRow[a];
        end else if (a == CTRL_A) begin
          if (busWrite) begin
            mBase = int'(busWdata & 32'hFF);
            mLen  = int'((busWdata >> 8) & 32'h1F);
            mIdx  = 0;
          end else mRd = 32'(mBase) | (32'(mLen) << 8) | (32'(mIdx) << 16);
        end else if (a == ENA_A) begin
          if (busWrite) mEna = busWdata[NREQ-1:0]; else mRd = 32'(mEna);
        end else if (a == WIN_A) begin
          t = mBase + mIdx;
          if (busWrite) begin
            if (t < NREGS) mRow[t] = busWdata;
          end else mRd = (t < NREGS) ? mRow[t] : 32'h0;
          mSet = mSet | oldEna;
          mIdx = (mIdx == mLen) ? 0 : mIdx + 1;
        end else if (!busWrite) mRd = '0;
      end
      for (int i = 0; i < NREQ; i++) begin
        if (mReq[i] && reqAck[i]) mReq[i] = 1'b0;
        else if (mSet[i])         mReq[i] = 1'b1;
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      compared++;
      if (busRdata !== mRd || dmaReq !== mReq) begin
        mismatched++;
        $display("FAIL %s: model compare rdata=%h req=%b expected rdata=%h req=%b",
                 curReq, busRdata, dmaReq, mRd, mReq);
      end
    end
  end

  task automatic chk(input string r, input logic [31:0] got, input logic [31:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: got %h expected %h", r, got, exp);
    end
  endtask

  // one bus cycle, entered and left at a falling edge
  task automatic acc(input bit wr, input int addr, input logic [31:0] d,
                     input logic [NREQ-1:0] ev = '0, input logic [NREQ-1:0] ak = '0);
    busValid = 1'b1; busWrite = wr; busAddr = ADDR_W'(addr); busWdata = d;
    evtIn = ev; reqAck = ak;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0; evtIn = '0; reqAck = '0;
  endtask

  task automatic idle(input logic [NREQ-1:0] ev = '0, input logic [NREQ-1:0] ak = '0);
    evtIn = ev; reqAck = ak;
    @(negedge clk);
    evtIn = '0; reqAck = '0;
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    finishRun();
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1", busRdata, 32'h0);
    chk("R1", 32'(dmaReq), 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    acc(0, CTRL_A, 0);
    chk("R1", busRdata, 32'h0);

    // R2 control fields and unmapped reads
    curReq = "R2";
    acc(1, CTRL_A, 32'hFFFF_0302);
    acc(0, CTRL_A, 0);
    chk("R2", busRdata, 32'h0000_0302);
    acc(0, 45, 0);
    chk("R2", busRdata, 32'h0);

    // R8 direct fills do not move the index
    curReq = "R8";
    for (int i = 0; i < NREGS; i++) acc(1, i, 32'h100 + i);
    acc(0, 5, 0);
    acc(0, CTRL_A, 0);
    chk("R8", busRdata, 32'h0000_0302);

    // R3 R5 read sweep with wrap, base 2, four transfers
    curReq = "R3";
    for (int k = 0; k < 6; k++) begin
      acc(0, WIN_A, 0);
      chk("R3", busRdata, 32'h102 + (k % 4));
    end
    curReq = "R5";
    acc(0, CTRL_A, 0);
    chk("R5", busRdata, 32'h0002_0302);

    // R6 control write clears index
    curReq = "R6";
    acc(1, CTRL_A, 32'h0302);
    acc(0, WIN_A, 0);
    chk("R6", busRdata, 32'h102);

    // R4 window writes, base 4, two transfers
    curReq = "R4";
    acc(1, CTRL_A, 32'h0104);
    acc(1, WIN_A, 32'hA);
    acc(1, WIN_A, 32'hB);
    acc(1, WIN_A, 32'hC);
    acc(0, 4, 0);
    chk("R4", busRdata, 32'hC);
    acc(0, 5, 0);
    chk("R4", busRdata, 32'hB);

    // R7 run past the last row
    curReq = "R7";
    acc(1, CTRL_A, 32'h0306);
    for (int k = 0; k < 4; k++) acc(1, WIN_A, 32'hD0 + k);
    acc(0, WIN_A, 0); chk("R7", busRdata, 32'hD0);
    acc(0, WIN_A, 0); chk("R7", busRdata, 32'hD1);
    acc(0, WIN_A, 0); chk("R7", busRdata, 32'h0);
    acc(0, WIN_A, 0); chk("R7", busRdata, 32'h0);
    acc(1, CTRL_A, 32'h00C8);
    acc(1, WIN_A, 32'hEE);
    acc(0, WIN_A, 0); chk("R7", busRdata, 32'h0);
    acc(0, 0, 0);     chk("R7", busRdata, 32'h100);

    // R9 window access requests every enabled line
    curReq = "R9";
    acc(1, ENA_A, 32'h5);
    acc(0, WIN_A, 0);
    chk("R9", 32'(dmaReq), 32'h5);

    // R11 hold then release
    curReq = "R11";
    idle(); idle();
    chk("R11", 32'(dmaReq), 32'h5);
    idle('0, 4'hF);
    chk("R11", 32'(dmaReq), 32'h0);

    // R10 events gated by enable
    curReq = "R10";
    idle(4'hF);
    chk("R10", 32'(dmaReq), 32'h5);
    idle('0, 4'hF);
    acc(1, ENA_A, 32'h0);
    idle(4'hF);
    chk("R10", 32'(dmaReq), 32'h0);

    // R11 acknowledge beats a same-cycle window access
    curReq = "R11";
    acc(1, ENA_A, 32'h1);
    acc(0, WIN_A, 0);
    chk("R11", 32'(dmaReq), 32'h1);
    acc(0, WIN_A, 0, '0, 4'h1);
    chk("R11", 32'(dmaReq), 32'h0);
    idle();
    chk("R11", 32'(dmaReq), 32'h0);
    acc(0, WIN_A, 0);
    chk("R11", 32'(dmaReq), 32'h1);
    idle('0, 4'hF);

    // mixed traffic against the model
    curReq = "R5";
    for (int k = 0; k < 400; k++) begin
      int sel;
      int ad;
      sel = int'($urandom_range(0, 9));
      if (sel < 5)       ad = WIN_A;
      else if (sel == 5) ad = CTRL_A;
      else if (sel == 6) ad = ENA_A;
      else               ad = int'($urandom_range(0, 15));
      if ($urandom_range(0, 3) == 0)
        idle(NREQ'($urandom), NREQ'($urandom));
      else
        acc(1'($urandom), ad,
            (ad == CTRL_A) ? ($urandom & 32'h0000_03FF) : $urandom,
            NREQ'($urandom), NREQ'($urandom));
    end

    finishRun();
  end
endmodule